// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a load/store unit and a memory bus that only takes naturally aligned transfers. It accepts one operand access at a time: a byte, word or long read or write at any byte address. It turns that access into one, two or three aligned bus transfers. Which transfers are used, and in what mix, depends on the operand size and on the two low address bits.

Operands are big-endian. The first transfer covers the lowest address, which holds the most significant bytes. Writes slice the operand into those pieces. Reads merge the returned pieces into one right-justified, zero-extended 32-bit value, and the completion strobe marks it valid.

Both data-carrying sides use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the splitter is idle, so a request offered while a split is in progress is held off and has no effect. On the bus side, a transfer completes on a cycle where `bus_valid` and `bus_ready` are both high. While `bus_ready` is low, the splitter holds every bus field steady. The memory must return read data combinationally in the cycle the transfer is accepted (zero-wait). `done` and `rsp_rdata` are plain status outputs.

Top module: `opnd_splitter`

## Requirements
- R1: While reset is applied and right after it is released, `req_ready` is 1, `bus_valid` is 0 and `done` is 0.
- R2: Size codes are 0 = byte, 1 = word, 2 = long; code 3 is treated as a byte. A byte access, a word at an even address and a long at an address that is a multiple of 4 each go out as exactly one bus transfer, with the request's address and size.
- R3: A word at an odd address becomes two byte transfers, at A and then A+1.
- R4: A long at an address with bit 0 set becomes three transfers: a byte at A, a word at A+1, then a byte at A+3. Each transfer starts at the byte that follows the previous one.
- R5: A long at an address whose low two bits are 10 becomes two word transfers, at A and then A+2.
- R6: Every word transfer on the bus has an even address, and every long transfer has an address that is a multiple of 4.
- R7: For writes, `bus_wdata` holds the piece right-justified: a byte in bits 7:0, a word in bits 15:0. The first piece carries the most significant bytes of the operand, so memory ends up holding the operand big-endian starting at A.
- R8: For reads, `bus_rdata` is taken right-justified in the same way. Once `done` is high, `rsp_rdata` equals the bytes at A..A+N-1, concatenated most significant first and zero-extended to 32 bits.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, the next cycle still has `bus_valid` 1, and `bus_addr`, `bus_size`, `bus_write` and `bus_wdata` are unchanged.
- R10: With `bus_ready` held high, the N transfers run in N consecutive cycles, starting the cycle after acceptance. `done` is high for exactly one cycle, the cycle after the last transfer is accepted. `req_ready` is high again in the following cycle.
- R11: A `req_valid` raised while `req_ready` is 0 is ignored: the split in progress keeps its transfer sequence, and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operand request offered |
| req_ready | output | 1 | Splitter idle; request taken when valid |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_valid | output | 1 | Bus transfer offered |
| bus_ready | input | 1 | Bus accepts transfer |
| bus_addr | output | AW | Transfer address (aligned to its size) |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Write piece, right-justified |
| bus_rdata | input | 32 | Read piece, right-justified, valid with bus_ready |
| done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Assembled read operand |

## Verification
The assertions check four things on every cycle. Bus fields must stay stable under back-pressure. Word and long transfers must be aligned. Each non-final transfer must be followed at once by a transfer at the next byte. `done` must be a single-cycle pulse that returns the block to idle. The bench scenarios are needed for the rest. Only they can show the exact split chosen for each size and address, the byte order of write slicing and read merging against a memory model, and the completion latency. They also cover a request arriving mid-split being ignored.

// File: rtl/opsplit_pkg.sv
package opsplit_pkg;
  localparam int DW = 32;
  localparam int MAX_PIECES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef struct packed {
    logic [1:0]                  count;
    size_e [MAX_PIECES-1:0]      sz;
  } plan_t;

  function automatic logic [2:0] size_bytes(size_e s);
    case (s)
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/opsplit_plan.sv
module opsplit_plan
  import opsplit_pkg::*;
(
  input  logic [1:0] lo,
  input  size_e      sz,
  output plan_t      plan
);
  always_comb begin
    plan.count = 2'd1;
    plan.sz    = {MAX_PIECES{SZ_BYTE}};
    case (sz)
      SZ_WORD: begin
        if (lo[0]) begin
          plan.count = 2'd2;
        end else begin
          plan.sz[0] = SZ_WORD;
        end
      end
      SZ_LONG: begin
        if (lo == 2'b00) begin
          plan.sz[0] = SZ_LONG;
        end else if (lo == 2'b10) begin
          plan.count = 2'd2;
          plan.sz[0] = SZ_WORD;
          plan.sz[1] = SZ_WORD;
        end else begin
          plan.count = 2'd3;
          plan.sz[1] = SZ_WORD;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opsplit_seq.sv
module opsplit_seq
  import opsplit_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  size_e         req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  plan_t         plan_in,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output size_e         bus_size,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          done
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} st_e;

  st_e           st_q;
  plan_t         plan_q;
  logic [1:0]    idx_q;
  logic [2:0]    off_q;
  logic [2:0]    tot_q;
  logic [AW-1:0] base_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;

  size_e         cur_sz;
  logic [2:0]    cur_nb;
  logic          last_c;
  logic [2:0]    sh_c;
  logic [DW-1:0] shifted_c;

  always_comb begin
    cur_sz    = plan_q.sz[idx_q];
    cur_nb    = size_bytes(cur_sz);
    last_c    = (idx_q == plan_q.count - 2'd1);
    sh_c      = tot_q - off_q - cur_nb;
    shifted_c = wd_q >> {sh_c, 3'b000};
    case (cur_sz)
      SZ_BYTE: bus_wdata = {{(DW-8){1'b0}}, shifted_c[7:0]};
      SZ_WORD: bus_wdata = {{(DW-16){1'b0}}, shifted_c[15:0]};
      default: bus_wdata = shifted_c;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign bus_valid = (st_q == ST_BUSY);
  assign bus_addr  = base_q + AW'(off_q);
  assign bus_size  = cur_sz;
  assign bus_write = wr_q;
  assign done      = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      plan_q <= '0;
      idx_q  <= '0;
      off_q  <= '0;
      tot_q  <= 3'd1;
      base_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            plan_q <= plan_in;
            idx_q  <= '0;
            off_q  <= '0;
            tot_q  <= size_bytes(req_size);
            base_q <= req_addr;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            st_q   <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (bus_ready) begin
            if (last_c) begin
              st_q <= ST_FIN;
            end else begin
              idx_q <= idx_q + 2'd1;
              off_q <= off_q + cur_nb;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size)
                                && $stable(bus_write) && $stable(bus_wdata));

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == SZ_WORD |-> !bus_addr[0]);

  // R6
  long_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == SZ_LONG |-> bus_addr[1:0] == 2'b00);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !last_c |=>
      bus_valid && (bus_addr == $past(bus_addr) + AW'(size_bytes($past(bus_size)))));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready && !bus_valid);
endmodule

// File: rtl/opsplit_gather.sv
module opsplit_gather
  import opsplit_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic          take_write,
  input  size_e         take_size,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (take && !take_write) begin
      case (take_size)
        SZ_BYTE: acc <= {acc[DW-9:0], bus_rdata[7:0]};
        SZ_WORD: acc <= {acc[DW-17:0], bus_rdata[15:0]};
        default: acc <= bus_rdata;
      endcase
    end
  end
endmodule

// File: rtl/opnd_splitter.sv
module opnd_splitter
  import opsplit_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          done,
  output logic [31:0]   rsp_rdata
);
  size_e req_sz;
  size_e bus_sz;
  plan_t plan;

  always_comb begin
    case (req_size)
      2'd1:    req_sz = SZ_WORD;
      2'd2:    req_sz = SZ_LONG;
      default: req_sz = SZ_BYTE;
    endcase
  end

  opsplit_plan u_plan (
    .lo   (req_addr[1:0]),
    .sz   (req_sz),
    .plan (plan)
  );

  opsplit_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_sz),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .plan_in   (plan),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_size  (bus_sz),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .done      (done)
  );

  assign bus_size = bus_sz;

  opsplit_gather u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (req_valid && req_ready),
    .take       (bus_valid && bus_ready),
    .take_write (bus_write),
    .take_size  (bus_sz),
    .bus_rdata  (bus_rdata),
    .acc        (rsp_rdata)
  );
endmodule

// File: tb/opnd_splitter_tb.sv
`timescale 1ns/1ps
module opnd_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        done;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  opnd_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .rsp_rdata(rsp_rdata)
  );

  // memory model: 64 bytes, right-justified bus data
  logic [7:0] mem [0:63];

  always_comb begin
    case (bus_size)
      2'd1:    bus_rdata = {16'h0, mem[bus_addr[5:0]], mem[6'(bus_addr[5:0] + 6'd1)]};
      2'd2:    bus_rdata = {mem[bus_addr[5:0]], mem[6'(bus_addr[5:0] + 6'd1)],
                            mem[6'(bus_addr[5:0] + 6'd2)], mem[6'(bus_addr[5:0] + 6'd3)]};
      default: bus_rdata = {24'h0, mem[bus_addr[5:0]]};
    endcase
  end

  // bus_ready driver
  bit stall_mode = 1'b0;
  bit tgl = 1'b0;
  always @(posedge clk) begin
    #1;
    tgl = ~tgl;
    bus_ready = stall_mode ? tgl : 1'b1;
  end

  // monitor at negedge
  int          cyc = 0;
  int          acc_cyc = 0;
  int          done_cyc = 0;
  int          nbeat = 0;
  int          dones = 0;
  int          stab_err = 0;
  logic [31:0] rd_done = '0;
  logic [31:0] log_addr [0:7];
  logic [1:0]  log_size [0:7];
  bit          prev_stall = 1'b0;
  logic [31:0] p_addr = '0;
  logic [31:0] p_wd = '0;
  logic [1:0]  p_size = '0;
  logic        p_w = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (req_valid && req_ready) acc_cyc = cyc;
    if (prev_stall && (!bus_valid || bus_addr != p_addr || bus_size != p_size ||
                       bus_wdata != p_wd || bus_write != p_w)) stab_err++;
    prev_stall = bus_valid && !bus_ready;
    p_addr = bus_addr; p_size = bus_size; p_wd = bus_wdata; p_w = bus_write;
    if (bus_valid && bus_ready) begin
      if (nbeat < 8) begin
        log_addr[nbeat] = bus_addr;
        log_size[nbeat] = bus_size;
      end
      nbeat++;
      if (bus_write) begin
        case (bus_size)
          2'd1: begin
            mem[bus_addr[5:0]] = bus_wdata[15:8];
            mem[6'(bus_addr[5:0] + 6'd1)] = bus_wdata[7:0];
          end
          2'd2: begin
            mem[bus_addr[5:0]] = bus_wdata[31:24];
            mem[6'(bus_addr[5:0] + 6'd1)] = bus_wdata[23:16];
            mem[6'(bus_addr[5:0] + 6'd2)] = bus_wdata[15:8];
            mem[6'(bus_addr[5:0] + 6'd3)] = bus_wdata[7:0];
          end
          default: mem[bus_addr[5:0]] = bus_wdata[7:0];
        endcase
      end
    end
    if (done) begin
      dones++;
      done_cyc = cyc;
      rd_done = rsp_rdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one operand access, checked against an independently computed plan
  task automatic do_op(input logic [31:0] a, input logic [1:0] s, input bit w,
                       input logic [31:0] wd, input bit stall, input bit poke,
                       input string tag);
    int en;
    int nb;
    int es [0:2];
    int off;
    logic [31:0] exp_rd;
    logic [31:0] got;
    nb = (s == 2'd2) ? 4 : (s == 2'd1) ? 2 : 1;
    es[0] = 0; es[1] = 0; es[2] = 0;
    if (s == 2'd1) begin
      if (a[0]) en = 2; else begin en = 1; es[0] = 1; end
    end else if (s == 2'd2) begin
      if (a[1:0] == 2'b00) begin en = 1; es[0] = 2; end
      else if (a[1:0] == 2'b10) begin en = 2; es[0] = 1; es[1] = 1; end
      else begin en = 3; es[1] = 1; end
    end else begin
      en = 1;
    end
    exp_rd = '0;
    for (int i = 0; i < nb; i++) exp_rd = {exp_rd[23:0], mem[6'(a[5:0] + 6'(i))]};

    nbeat = 0; dones = 0; stab_err = 0; acc_cyc = 0; done_cyc = 0;
    stall_mode = stall;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = w; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_addr = a + 32'd8; req_size = 2'd0; req_write = ~w;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    for (int i = 0; i < 60 && dones == 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
    stall_mode = 1'b0;

    chk(nbeat == en, tag, "transfer count", 32'(nbeat), 32'(en));
    off = 0;
    for (int i = 0; i < en && i < nbeat; i++) begin
      chk(log_addr[i] == a + 32'(off), tag, $sformatf("piece %0d address", i),
          log_addr[i], a + 32'(off));
      chk(log_size[i] == 2'(es[i]), tag, $sformatf("piece %0d size", i),
          32'(log_size[i]), 32'(es[i]));
      if (log_size[i] == 2'd1)
        chk(!log_addr[i][0], "R6", "word transfer alignment", log_addr[i], {log_addr[i][31:1], 1'b0});
      if (log_size[i] == 2'd2)
        chk(log_addr[i][1:0] == 2'b00, "R6", "long transfer alignment", log_addr[i], {log_addr[i][31:2], 2'b00});
      off += (es[i] == 2) ? 4 : (es[i] == 1) ? 2 : 1;
    end
    chk(dones == 1, "R10", "done pulse count", 32'(dones), 32'd1);
    chk(req_ready == 1'b1, "R10", "ready after completion", 32'(req_ready), 32'd1);
    if (!stall)
      chk(done_cyc == acc_cyc + en + 1, "R10", "done latency", 32'(done_cyc - acc_cyc), 32'(en + 1));
    else
      chk(stab_err == 0, "R9", "bus fields steady under back-pressure", 32'(stab_err), 32'd0);
    if (poke) begin
      chk(nbeat == en, "R11", "busy request ignored (transfers)", 32'(nbeat), 32'(en));
      chk(dones == 1, "R11", "busy request ignored (done)", 32'(dones), 32'd1);
    end
    if (w) begin
      got = '0;
      for (int i = 0; i < nb; i++) got = {got[23:0], mem[6'(a[5:0] + 6'(i))]};
      chk(got == (wd & (nb == 4 ? 32'hFFFF_FFFF : nb == 2 ? 32'h0000_FFFF : 32'h0000_00FF)),
          "R7", "memory after write", got, wd);
    end else begin
      chk(rd_done == exp_rd, "R8", "assembled read data", rd_done, exp_rd);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'd1);
    chk(bus_valid == 1'b0, "R1", "bus_valid in reset", 32'(bus_valid), 32'd0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R1", "idle after reset",
        {29'd0, req_ready, bus_valid, done}, 32'h4);
  endtask

  task automatic t_single();
    do_op(32'h13, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, "R2");
    do_op(32'h0A, 2'd1, 1'b0, 32'h0, 1'b0, 1'b0, "R2");
    do_op(32'h20, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b0, "R2");
    do_op(32'h20, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R2");
    do_op(32'h15, 2'd3, 1'b1, 32'h0000_005A, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_word_odd();
    do_op(32'h05, 2'd1, 1'b0, 32'h0, 1'b0, 1'b0, "R3");
    do_op(32'h0B, 2'd1, 1'b1, 32'h0000BEEF, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_long_odd();
    do_op(32'h11, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R4");
    do_op(32'h17, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R4");
    do_op(32'h29, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b0, "R4");
    do_op(32'h29, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_long_half();
    do_op(32'h0E, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R5");
    do_op(32'h32, 2'd2, 1'b1, 32'hCAFEF00D, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_stall();
    do_op(32'h01, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, "R4");
    do_op(32'h36, 2'd2, 1'b1, 32'h5566_7788, 1'b1, 1'b0, "R5");
    do_op(32'h07, 2'd1, 1'b1, 32'h0000_9ABC, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_busy();
    do_op(32'h03, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1, "R4");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    t_reset();
    t_single();
    t_word_odd();
    t_long_odd();
    t_long_half();
    t_stall();
    t_busy();
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule